// File: doc/BRIEF.md
# Eight-Channel Input Event Counter Bank

This block counts edges on a bank of digital inputs. Each input has its own counter with a programmable preset (reload) value and a programmable match value. Software or a local controller drives the block only through single-cycle commands. Each command is an 8-bit code with a 16-bit operand, and every command returns one word on a feedback port one cycle later.

The inputs are asynchronous. They pass through a two-flop synchroniser and an edge detector. Per-channel masks then set which counters run, which edge each counter counts, and whether a wrap or a match raises a sticky flag. The flags can be read either as a three-bit summary or as two per-channel bytes. Either read clears all flags.

Top module: `evt_counter_bank`

## Requirements
- R1: After reset every counter and every preset is 0x0000, every match value is 0x8000, the enable, edge-select, overflow-enable and match-enable masks are all zero, and no flag is set.
- R2: A transition applied to an input between clock edges updates its counter at the third rising clock edge after it is applied, and not earlier.
- R3: Command 0x2C writes the edge-select mask. Bit i clear makes counter i count rising edges; bit i set makes it count falling edges.
- R4: Command 0x28 writes the count-enable mask. A counter whose bit is clear ignores its input and holds its value.
- R5: Command 0x40+i writes the preset of counter i. Command 0x29 reloads from its preset every counter whose bit is set in operand bits 7:0, and leaves the other counters unchanged. A reload takes priority over a count in the same cycle.
- R6: A counted edge at 0xFFFF reloads the counter from its preset instead of wrapping to zero. It sets that channel's overflow flag only if bit i of the overflow-enable mask (command 0x2A) is set.
- R7: Command 0x48+i writes the match value of counter i. A counted edge whose new value equals the match value sets the channel's match flag only if bit i of the match-enable mask (command 0x2B) is set.
- R8: Command 0x60 returns bit 0 = any match flag, bit 1 = 0 and bit 2 = any overflow flag. Command 0x62 returns the match flags in bits 7:0 and the overflow flags in bits 15:8. Either read clears all flags, except a flag set by an event in the same cycle.
- R9: Every command makes fb_valid high for exactly the next cycle, with fb_code echoing the command code. Command 0x2F returns the count of the channel in operand bits 2:0. A write command echoes its operand, and an unknown code returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | NCH (8) | Asynchronous event inputs |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_code | input | 8 | Command code |
| cmd_value | input | 16 | Command operand |
| fb_valid | output | 1 | Feedback word valid |
| fb_code | output | 8 | Code of the command being answered |
| fb_data | output | 16 | Feedback word |

## Verification
An input level applied between edges reaches its counter at the third rising edge. Feedback for a command issued at one edge is registered at the next edge. The bench therefore waits four cycles after every input change before it issues a read, and samples feedback at the falling edge that follows the capturing edge. R2 is the one place this is pinned exactly: two back-to-back reads follow an input change, and the first must still see the old count while the second sees the incremented count. Flag reads are ordered so that the clearing effect of one read is observed by the next.

// File: rtl/evb_pkg.sv
package evb_pkg;
    localparam logic [7:0] CMD_ENABLE     = 8'h28;
    localparam logic [7:0] CMD_RELOAD     = 8'h29;
    localparam logic [7:0] CMD_OVF_EN     = 8'h2A;
    localparam logic [7:0] CMD_MATCH_EN   = 8'h2B;
    localparam logic [7:0] CMD_EDGE_SEL   = 8'h2C;
    localparam logic [7:0] CMD_READ_CNT   = 8'h2F;
    localparam logic [7:0] CMD_PRESET_0   = 8'h40;
    localparam logic [7:0] CMD_MATCH_0    = 8'h48;
    localparam logic [7:0] CMD_SUMMARY    = 8'h60;
    localparam logic [7:0] CMD_CHAN_FLAGS = 8'h62;

    localparam int SUM_MATCH_BIT = 0;
    localparam int SUM_OVF_BIT   = 2;
    localparam int FB_W          = 16;
endpackage

// File: rtl/evb_edge.sv
module evb_edge #(
    parameter int NCH    = 8,
    parameter int STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] din,
    input  logic [NCH-1:0] edge_sel,
    output logic [NCH-1:0] tick
);
    typedef struct packed {
        logic [STAGES-1:0][NCH-1:0] sync;
        logic [NCH-1:0]             prev;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic [NCH-1:0] lvl;

    always_comb begin
        st_d         = st_q;
        st_d.sync[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            st_d.sync[s] = st_q.sync[s-1];
        end
        lvl       = st_q.sync[STAGES-1];
        st_d.prev = lvl;
        tick      = (lvl & ~st_q.prev & ~edge_sel) | (~lvl & st_q.prev & edge_sel);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/evb_chan.sv
module evb_chan #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          count_en,
    input  logic          load,
    input  logic          wr_preset,
    input  logic          wr_match,
    input  logic [CW-1:0] wr_data,
    input  logic          ovf_en,
    input  logic          match_en,
    input  logic          clr_flags,
    output logic [CW-1:0] cnt,
    output logic          match_flag,
    output logic          ovf_flag
);
    localparam logic [CW-1:0] CNT_MAX    = '1;
    localparam logic [CW-1:0] MATCH_INIT = CW'(1) << (CW - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] preset;
        logic [CW-1:0] match;
        logic          mflag;
        logic          oflag;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic [CW-1:0] adv;
    logic          at_max;

    always_comb begin
        st_d   = st_q;
        at_max = (st_q.cnt == CNT_MAX);
        adv    = at_max ? st_q.preset : st_q.cnt + CW'(1);
        if (clr_flags) begin
            st_d.mflag = 1'b0;
            st_d.oflag = 1'b0;
        end
        if (load) begin
            st_d.cnt = st_q.preset;
        end else if (tick && count_en) begin
            st_d.cnt = adv;
            if (at_max && ovf_en) begin
                st_d.oflag = 1'b1;
            end
            if ((adv == st_q.match) && match_en) begin
                st_d.mflag = 1'b1;
            end
        end
        if (wr_preset) begin
            st_d.preset = wr_data;
        end
        if (wr_match) begin
            st_d.match = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.match <= MATCH_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt        = st_q.cnt;
    assign match_flag = st_q.mflag;
    assign ovf_flag   = st_q.oflag;
endmodule

// File: rtl/evt_counter_bank.sv
module evt_counter_bank
    import evb_pkg::*;
#(
    parameter int NCH = 8,
    parameter int CW  = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] din,
    input  logic           cmd_valid,
    input  logic [7:0]     cmd_code,
    input  logic [15:0]    cmd_value,
    output logic           fb_valid,
    output logic [7:0]     fb_code,
    output logic [15:0]    fb_data
);
    localparam int SELW = (NCH > 1) ? $clog2(NCH) : 1;

    typedef struct packed {
        logic [NCH-1:0]  en;
        logic [NCH-1:0]  esel;
        logic [NCH-1:0]  oen;
        logic [NCH-1:0]  men;
        logic            fb_valid;
        logic [7:0]      fb_code;
        logic [FB_W-1:0] fb_data;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [NCH-1:0]  tick;
    logic [NCH-1:0]  load_mask;
    logic [NCH-1:0]  wr_preset;
    logic [NCH-1:0]  wr_match;
    logic            clr_flags;
    logic [NCH-1:0]  mflags;
    logic [NCH-1:0]  oflags;
    logic [CW-1:0]   cnt_arr [NCH];
    logic [NCH*CW-1:0] cnt_flat;
    logic [SELW-1:0] rd_sel;

    evb_edge #(.NCH(NCH), .STAGES(2)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (din),
        .edge_sel (st_q.esel),
        .tick     (tick)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        evb_chan #(.CW(CW)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick       (tick[i]),
            .count_en   (st_q.en[i]),
            .load       (load_mask[i]),
            .wr_preset  (wr_preset[i]),
            .wr_match   (wr_match[i]),
            .wr_data    (cmd_value[CW-1:0]),
            .ovf_en     (st_q.oen[i]),
            .match_en   (st_q.men[i]),
            .clr_flags  (clr_flags),
            .cnt        (cnt_arr[i]),
            .match_flag (mflags[i]),
            .ovf_flag   (oflags[i])
        );
        assign cnt_flat[i*CW +: CW] = cnt_arr[i];
    end

    always_comb begin
        st_d          = st_q;
        load_mask     = '0;
        wr_preset     = '0;
        wr_match      = '0;
        clr_flags     = 1'b0;
        rd_sel        = cmd_value[SELW-1:0];
        st_d.fb_valid = cmd_valid;
        if (cmd_valid) begin
            st_d.fb_code = cmd_code;
            st_d.fb_data = '0;
            for (int i = 0; i < NCH; i++) begin
                if (cmd_code == CMD_PRESET_0 + 8'(i)) begin
                    wr_preset[i] = 1'b1;
                    st_d.fb_data = cmd_value;
                end
                if (cmd_code == CMD_MATCH_0 + 8'(i)) begin
                    wr_match[i]  = 1'b1;
                    st_d.fb_data = cmd_value;
                end
            end
            case (cmd_code)
                CMD_ENABLE: begin
                    st_d.en      = cmd_value[NCH-1:0];
                    st_d.fb_data = cmd_value;
                end
                CMD_EDGE_SEL: begin
                    st_d.esel    = cmd_value[NCH-1:0];
                    st_d.fb_data = cmd_value;
                end
                CMD_OVF_EN: begin
                    st_d.oen     = cmd_value[NCH-1:0];
                    st_d.fb_data = cmd_value;
                end
                CMD_MATCH_EN: begin
                    st_d.men     = cmd_value[NCH-1:0];
                    st_d.fb_data = cmd_value;
                end
                CMD_RELOAD: begin
                    load_mask    = cmd_value[NCH-1:0];
                    st_d.fb_data = cmd_value;
                end
                CMD_READ_CNT: begin
                    st_d.fb_data = FB_W'(cnt_arr[rd_sel]);
                end
                CMD_SUMMARY: begin
                    clr_flags = 1'b1;
                    st_d.fb_data[SUM_MATCH_BIT] = |mflags;
                    st_d.fb_data[SUM_OVF_BIT]   = |oflags;
                end
                CMD_CHAN_FLAGS: begin
                    clr_flags = 1'b1;
                    st_d.fb_data[0 +: NCH] = mflags;
                    st_d.fb_data[8 +: NCH] = oflags;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fb_valid = st_q.fb_valid;
    assign fb_code  = st_q.fb_code;
    assign fb_data  = st_q.fb_data;
endmodule

// File: rtl/evb_chk.sv
module evb_chk #(
    parameter int NCH = 8,
    parameter int CW  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [7:0]        cmd_code,
    input logic              fb_valid,
    input logic [7:0]        fb_code,
    input logic [NCH-1:0]    en_mask,
    input logic [NCH-1:0]    ovf_en,
    input logic [NCH-1:0]    match_en,
    input logic [NCH-1:0]    ovf_flags,
    input logic [NCH-1:0]    match_flags,
    input logic [NCH*CW-1:0] cnt_flat
);
    // R9
    fb_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> (fb_valid && fb_code == $past(cmd_code)));

    // R9
    fb_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !fb_valid);

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_mask == '0 && !(cmd_valid && cmd_code == evb_pkg::CMD_RELOAD)) |=> $stable(cnt_flat));

    // R6
    ovf_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fb_valid |-> ((ovf_flags & ~$past(ovf_flags) & ~$past(ovf_en)) == '0));

    // R7
    match_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fb_valid |-> ((match_flags & ~$past(match_flags) & ~$past(match_en)) == '0));

    // R7
    match_gate_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fb_valid |-> ((match_flags & ~$past(match_flags) & ~$past(match_en)) == '0));
endmodule

bind evt_counter_bank evb_chk #(.NCH(NCH), .CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_code    (cmd_code),
    .fb_valid    (fb_valid),
    .fb_code     (fb_code),
    .en_mask     (st_q.en),
    .ovf_en      (st_q.oen),
    .match_en    (st_q.men),
    .ovf_flags   (oflags),
    .match_flags (mflags),
    .cnt_flat    (cnt_flat)
);

// File: tb/evt_counter_bank_tb.sv
module evt_counter_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  din = '0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_code = '0;
    logic [15:0] cmd_value = '0;
    logic        fb_valid;
    logic [7:0]  fb_code;
    logic [15:0] fb_data;

    int total = 0;
    int bad = 0;
    logic [7:0]  last_code;
    logic        last_valid;
    logic [15:0] r;
    logic [15:0] cnt_m [8];

    evt_counter_bank u_dut (
        .clk(clk), .rst_n(rst_n), .din(din),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_value(cmd_value),
        .fb_valid(fb_valid), .fb_code(fb_code), .fb_data(fb_data)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] c, input logic [15:0] v, output logic [15:0] res);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_code  = c;
        cmd_value = v;
        @(negedge clk);
        cmd_valid  = 1'b0;
        res        = fb_data;
        last_code  = fb_code;
        last_valid = fb_valid;
    endtask

    task automatic wr(input logic [7:0] c, input logic [15:0] v);
        logic [15:0] dummy;
        send(c, v, dummy);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse(input logic [7:0] m);
        @(negedge clk);
        din = din | m;
        settle();
        din = din & ~m;
        settle();
    endtask

    initial begin
        #400000;
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] prev;
        logic [7:0] v;
        logic [7:0] en_m;
        logic [7:0] es_m;
        logic [15:0] base4;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: reset state of counters and flags
        for (int i = 0; i < 8; i++) begin
            send(8'h2F, 16'(i), r);
            check("R1 count after reset", r, 16'h0000);
        end
        send(8'h62, 16'h0, r);
        check("R1 flags after reset", r, 16'h0000);
        // R9: feedback valid for exactly one cycle, code echoed
        check("R9 fb_valid after command", {15'b0, last_valid}, 16'h0001);
        check("R9 fb_code echo", {8'b0, last_code}, 16'h0062);
        @(negedge clk);
        check("R9 fb_valid drops", {15'b0, fb_valid}, 16'h0000);

        // R3 / R4: edge-select and enable sweep
        en_m = 8'hDB;
        es_m = 8'hF0;
        wr(8'h28, {8'h0, en_m});
        wr(8'h2C, {8'h0, es_m});
        for (int i = 0; i < 8; i++) cnt_m[i] = 16'h0;
        prev = 8'h00;
        for (int k = 0; k <= 24; k++) begin
            v = (k == 24) ? 8'h00 : 8'((k * 53 + 17) & 8'hFF);
            for (int i = 0; i < 8; i++) begin
                if (en_m[i] && ((!es_m[i] && v[i] && !prev[i]) || (es_m[i] && !v[i] && prev[i])))
                    cnt_m[i] = cnt_m[i] + 16'h1;
            end
            @(negedge clk);
            din = v;
            settle();
            prev = v;
        end
        for (int i = 0; i < 8; i++) begin
            send(8'h2F, 16'(i), r);
            if (en_m[i]) check(es_m[i] ? "R3 falling count" : "R3 rising count", r, cnt_m[i]);
            else         check("R4 disabled counter holds", r, 16'h0000);
        end

        // R5: presets and masked reload
        for (int i = 0; i < 8; i++) begin
            send(8'h40 + 8'(i), 16'h0100 * 16'(i) + 16'h5, r);
            if (i == 3) check("R9 write echo", r, 16'h0305);
        end
        wr(8'h29, 16'h00A5);
        for (int i = 0; i < 8; i++) begin
            if (8'hA5 & (8'h1 << i)) cnt_m[i] = 16'h0100 * 16'(i) + 16'h5;
            send(8'h2F, 16'(i), r);
            check("R5 reload by mask", r, cnt_m[i]);
        end
        send(8'h77, 16'h1234, r);
        check("R9 unknown code", r, 16'h0000);

        // R6: overflow reload and gated flag
        wr(8'h2C, 16'h0000);
        wr(8'h28, 16'h00FF);
        wr(8'h42, 16'hFFFE);
        wr(8'h43, 16'hFFFE);
        wr(8'h29, 16'h000C);
        wr(8'h2A, 16'h0004);
        pulse(8'h0C);
        pulse(8'h0C);
        send(8'h2F, 16'd2, r);
        check("R6 wrap reloads preset ch2", r, 16'hFFFE);
        send(8'h2F, 16'd3, r);
        check("R6 wrap reloads preset ch3", r, 16'hFFFE);
        send(8'h60, 16'h0, r);
        check("R8 summary overflow bit", r, 16'h0004);
        send(8'h62, 16'h0, r);
        check("R8 read clears flags", r, 16'h0000);
        pulse(8'h0C);
        pulse(8'h0C);
        send(8'h62, 16'h0, r);
        check("R6 overflow flag only where enabled", r, 16'h0400);

        // R7: match against default and programmed values
        wr(8'h40, 16'h7FFE);
        wr(8'h29, 16'h0001);
        wr(8'h41, 16'h0000);
        wr(8'h49, 16'h0003);
        wr(8'h29, 16'h0002);
        wr(8'h2B, 16'h0003);
        pulse(8'h03);
        send(8'h62, 16'h0, r);
        check("R7 no match before value", r, 16'h0000);
        pulse(8'h03);
        send(8'h2F, 16'd0, r);
        check("R1 default match reached count", r, 16'h8000);
        send(8'h60, 16'h0, r);
        check("R7 default match 0x8000 flags", r, 16'h0001);
        pulse(8'h03);
        send(8'h62, 16'h0, r);
        check("R7 programmed match ch1", r, 16'h0002);

        // R2: count not visible before the third edge, visible after
        send(8'h2F, 16'd4, r);
        base4 = r;
        @(negedge clk);
        din = 8'h10;
        send(8'h2F, 16'd4, r);
        check("R2 count not yet updated", r, base4);
        send(8'h2F, 16'd4, r);
        check("R2 count updated at third edge", r, base4 + 16'h1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule